// File: doc/BRIEF.md
# Atomic Memory Update Engine

This block holds a local array of memory words and applies atomic read-modify-write commands to it. The commands come from network traffic. A single packet can carry several independent updates. The packet is presented as a stream of commands on a valid/ready channel, and the engine applies them strictly one after another. Each command carries:

- an opcode,
- a word address,
- an operand,
- a compare value,
- a fetch flag,
- a tag.

Each update is finished and written back before the next command is accepted. A later update to the same word therefore always sees the earlier result, and no write is lost. When a command asks for its data, the engine returns the word as it was before the update. The response goes out on a separate valid/ready channel and carries the command's tag and an applied flag.

The controller is a four-state machine:

- **CLEAR** runs after reset. It zeroes one word per cycle.
- **IDLE** accepts a command and launches the memory read.
- **EXEC** computes the new value and writes it back.
- **RESP** holds a fetched response until it is taken.

The transitions are:

- CLEAR to IDLE after the last word has been zeroed.
- IDLE to EXEC on an accepted command.
- EXEC to RESP when the command fetches, and EXEC to IDLE when it does not.
- RESP to IDLE once the response has been accepted.

Top module: `amo_engine`

## Requirements
- R1: After reset, the engine zeroes all DEPTH words in DEPTH cycles. cmd_ready stays low for exactly those DEPTH cycles, and every word then reads as zero.
- R2: Opcode 0 (add) stores old + operand modulo 2^64. A carry out of the top bit is dropped and nothing reports it.
- R3: Opcodes 1, 2 and 3 store the bitwise AND, OR and XOR of the old word and the operand.
- R4: Opcode 4 (compare-and-swap) stores the operand only when the old word equals the compare value. Otherwise the word is unchanged. rsp_ok is 1 on a swap and 0 on a miss.
- R5: A command with cmd_fetch=1 produces exactly one response, carrying the pre-update word and the command's tag. A command with cmd_fetch=0 produces no response.
- R6: Commands take effect in acceptance order, and each one sees the results of all earlier ones, including back-to-back updates to one address. After an accepted command, cmd_ready is low for the following cycle.
- R7: While rsp_valid is high and rsp_ready is low, rsp_data, rsp_tag and rsp_ok stay stable. cmd_ready is low whenever rsp_valid is high. No accepted command is lost or applied twice under backpressure.
- R8: Opcodes 5 to 7 leave memory unchanged. If they fetch, they return the current word with rsp_ok=0. rsp_ok is 1 for opcodes 0 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted this cycle when valid |
| cmd_op | input | 3 | Update opcode (0 add, 1 and, 2 or, 3 xor, 4 compare-and-swap) |
| cmd_addr | input | AW | Word address |
| cmd_operand | input | DW | Operand or swap value |
| cmd_compare | input | DW | Compare value for compare-and-swap |
| cmd_fetch | input | 1 | Return the pre-update word |
| cmd_tag | input | TW | Tag echoed in the response |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken this cycle when valid |
| rsp_data | output | DW | Pre-update word |
| rsp_tag | output | TW | Tag of the fetching command |
| rsp_ok | output | 1 | Update applied (swap hit, or opcode 0 to 3) |

## Verification
The hardest case to reach from the ports is a fetched response stuck under backpressure while further commands, often to the same word, queue up behind it. If that case is handled wrongly, a command can be dropped, applied twice, or read stale data. The bench reaches it by throttling rsp_ready with a pseudo-random pattern. At the same time it sends long runs of mixed commands over a pool of only four addresses, so that consecutive updates collide and every response may wait several cycles. A reset in the middle of the run, after the words have been dirtied, shows that clearing restores them to zero.

// File: rtl/amo_pkg.sv
package amo_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_AND = 3'd1,
        OP_OR  = 3'd2,
        OP_XOR = 3'd3,
        OP_CAS = 3'd4
    } amo_op_e;

    typedef enum logic [1:0] {
        ST_CLEAR = 2'd0,
        ST_IDLE  = 2'd1,
        ST_EXEC  = 2'd2,
        ST_RESP  = 2'd3
    } amo_state_e;

endpackage

// File: rtl/amo_mem.sv
module amo_mem #(
    parameter int DW    = 64,
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata
);

    logic [DW-1:0] words [DEPTH];

    // One-cycle synchronous read, independent write port.
    always_ff @(posedge clk) begin
        if (we) begin
            words[waddr] <= wdata;
        end
        if (re) begin
            rdata <= words[raddr];
        end
    end

endmodule

// File: rtl/amo_alu.sv
module amo_alu
    import amo_pkg::*;
#(
    parameter int DW = 64
) (
    input  logic [2:0]    op,
    input  logic [DW-1:0] old_val,
    input  logic [DW-1:0] operand,
    input  logic [DW-1:0] compare,
    output logic [DW-1:0] new_val,
    output logic          do_write
);

    always_comb begin
        new_val  = old_val;
        do_write = 1'b0;
        unique case (op)
            OP_ADD: begin
                new_val  = old_val + operand;   // wraps, carry dropped
                do_write = 1'b1;
            end
            OP_AND: begin
                new_val  = old_val & operand;
                do_write = 1'b1;
            end
            OP_OR: begin
                new_val  = old_val | operand;
                do_write = 1'b1;
            end
            OP_XOR: begin
                new_val  = old_val ^ operand;
                do_write = 1'b1;
            end
            OP_CAS: begin
                if (old_val == compare) begin
                    new_val  = operand;
                    do_write = 1'b1;
                end
            end
            default: begin
                new_val  = old_val;
                do_write = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/amo_ctrl.sv
module amo_ctrl
    import amo_pkg::*;
#(
    parameter int DW    = 64,
    parameter int DEPTH = 64,
    parameter int TW    = 8,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    // command channel
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic [2:0]    cmd_op,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_operand,
    input  logic [DW-1:0] cmd_compare,
    input  logic          cmd_fetch,
    input  logic [TW-1:0] cmd_tag,
    // response channel
    output logic          rsp_valid,
    input  logic          rsp_ready,
    output logic [DW-1:0] rsp_data,
    output logic [TW-1:0] rsp_tag,
    output logic          rsp_ok,
    // memory side
    output logic          mem_re,
    output logic [AW-1:0] mem_raddr,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic [DW-1:0] mem_wdata,
    // arithmetic side
    output logic [2:0]    alu_op,
    output logic [DW-1:0] alu_operand,
    output logic [DW-1:0] alu_compare,
    input  logic [DW-1:0] alu_new,
    input  logic          alu_write
);

    localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

    amo_state_e    state_q, state_d;
    logic [AW-1:0] clr_addr_q;
    logic [2:0]    op_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] operand_q;
    logic [DW-1:0] compare_q;
    logic          fetch_q;
    logic [TW-1:0] tag_q;
    logic [DW-1:0] rsp_data_q;
    logic [TW-1:0] rsp_tag_q;
    logic          rsp_ok_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR: if (clr_addr_q == LAST_ADDR) state_d = ST_IDLE;
            ST_IDLE:  if (cmd_valid)                state_d = ST_EXEC;
            ST_EXEC:  state_d = fetch_q ? ST_RESP : ST_IDLE;
            ST_RESP:  if (rsp_ready)                state_d = ST_IDLE;
            default:  state_d = ST_CLEAR;
        endcase
    end

    // Outputs per state
    always_comb begin
        cmd_ready = 1'b0;
        rsp_valid = 1'b0;
        mem_re    = 1'b0;
        mem_raddr = cmd_addr;
        mem_we    = 1'b0;
        mem_waddr = addr_q;
        mem_wdata = alu_new;
        unique case (state_q)
            ST_CLEAR: begin
                mem_we    = 1'b1;
                mem_waddr = clr_addr_q;
                mem_wdata = '0;
            end
            ST_IDLE: begin
                cmd_ready = 1'b1;
                mem_re    = cmd_valid;
            end
            ST_EXEC: begin
                mem_we = alu_write;
            end
            ST_RESP: begin
                rsp_valid = 1'b1;
            end
            default: begin
                cmd_ready = 1'b0;
            end
        endcase
    end

    // Clear sweep address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr_addr_q <= '0;
        end else if (state_q == ST_CLEAR) begin
            clr_addr_q <= clr_addr_q + 1'b1;
        end
    end

    // Command capture on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q      <= '0;
            addr_q    <= '0;
            operand_q <= '0;
            compare_q <= '0;
            fetch_q   <= 1'b0;
            tag_q     <= '0;
        end else if (state_q == ST_IDLE && cmd_valid) begin
            op_q      <= cmd_op;
            addr_q    <= cmd_addr;
            operand_q <= cmd_operand;
            compare_q <= cmd_compare;
            fetch_q   <= cmd_fetch;
            tag_q     <= cmd_tag;
        end
    end

    // Response capture in the execute cycle; held through RESP
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_data_q <= '0;
            rsp_tag_q  <= '0;
            rsp_ok_q   <= 1'b0;
        end else if (state_q == ST_EXEC && fetch_q) begin
            rsp_data_q <= mem_rdata;
            rsp_tag_q  <= tag_q;
            rsp_ok_q   <= alu_write;
        end
    end

    assign alu_op      = op_q;
    assign alu_operand = operand_q;
    assign alu_compare = compare_q;
    assign rsp_data    = rsp_data_q;
    assign rsp_tag     = rsp_tag_q;
    assign rsp_ok      = rsp_ok_q;

endmodule

// File: rtl/amo_engine.sv
module amo_engine #(
    parameter int DW    = 64,
    parameter int DEPTH = 64,
    parameter int TW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic [2:0]    cmd_op,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_operand,
    input  logic [DW-1:0] cmd_compare,
    input  logic          cmd_fetch,
    input  logic [TW-1:0] cmd_tag,
    output logic          rsp_valid,
    input  logic          rsp_ready,
    output logic [DW-1:0] rsp_data,
    output logic [TW-1:0] rsp_tag,
    output logic          rsp_ok
);

    logic          mem_re;
    logic [AW-1:0] mem_raddr;
    logic [DW-1:0] mem_rdata;
    logic          mem_we;
    logic [AW-1:0] mem_waddr;
    logic [DW-1:0] mem_wdata;
    logic [2:0]    alu_op;
    logic [DW-1:0] alu_operand;
    logic [DW-1:0] alu_compare;
    logic [DW-1:0] alu_new;
    logic          alu_write;

    amo_ctrl #(.DW(DW), .DEPTH(DEPTH), .TW(TW), .AW(AW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_ready   (cmd_ready),
        .cmd_op      (cmd_op),
        .cmd_addr    (cmd_addr),
        .cmd_operand (cmd_operand),
        .cmd_compare (cmd_compare),
        .cmd_fetch   (cmd_fetch),
        .cmd_tag     (cmd_tag),
        .rsp_valid   (rsp_valid),
        .rsp_ready   (rsp_ready),
        .rsp_data    (rsp_data),
        .rsp_tag     (rsp_tag),
        .rsp_ok      (rsp_ok),
        .mem_re      (mem_re),
        .mem_raddr   (mem_raddr),
        .mem_rdata   (mem_rdata),
        .mem_we      (mem_we),
        .mem_waddr   (mem_waddr),
        .mem_wdata   (mem_wdata),
        .alu_op      (alu_op),
        .alu_operand (alu_operand),
        .alu_compare (alu_compare),
        .alu_new     (alu_new),
        .alu_write   (alu_write)
    );

    amo_mem #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_mem (
        .clk   (clk),
        .re    (mem_re),
        .raddr (mem_raddr),
        .rdata (mem_rdata),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata)
    );

    amo_alu #(.DW(DW)) u_alu (
        .op       (alu_op),
        .old_val  (mem_rdata),
        .operand  (alu_operand),
        .compare  (alu_compare),
        .new_val  (alu_new),
        .do_write (alu_write)
    );

endmodule

// File: rtl/amo_engine_chk.sv
module amo_engine_chk #(
    parameter int DW = 64,
    parameter int TW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic          cmd_ready,
    input logic          cmd_fetch,
    input logic [TW-1:0] cmd_tag,
    input logic          rsp_valid,
    input logic          rsp_ready,
    input logic [DW-1:0] rsp_data,
    input logic [TW-1:0] rsp_tag,
    input logic          rsp_ok
);

    // R7: a held response does not change
    a_r7_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data)
                                    && $stable(rsp_tag) && $stable(rsp_ok));

    // R7: no command accepted while a response waits
    a_r7_cmd_stall: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !cmd_ready);

    // R6: one command at a time
    a_r6_one_at_a_time: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready |=> !cmd_ready);

    // R5: fetching command answers two cycles later with its tag
    a_r5_fetch_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready && cmd_fetch |=> ##1
            (rsp_valid && rsp_tag == $past(cmd_tag, 2)));

    // R5: non-fetching command raises no response
    a_r5_no_fetch_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready && !cmd_fetch |=> ##1 !rsp_valid);

endmodule

bind amo_engine amo_engine_chk #(.DW(DW), .TW(TW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_fetch (cmd_fetch),
    .cmd_tag   (cmd_tag),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_data  (rsp_data),
    .rsp_tag   (rsp_tag),
    .rsp_ok    (rsp_ok)
);

// File: tb/amo_engine_test.sv
module amo_engine_test;

    localparam int CLK_PERIOD = 10;
    localparam int DW    = 64;
    localparam int DEPTH = 64;
    localparam int TW    = 8;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [2:0]    cmd_op = '0;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_operand = '0;
    logic [DW-1:0] cmd_compare = '0;
    logic          cmd_fetch = 1'b0;
    logic [TW-1:0] cmd_tag = '0;
    logic          rsp_valid;
    logic          rsp_ready = 1'b1;
    logic [DW-1:0] rsp_data;
    logic [TW-1:0] rsp_tag;
    logic          rsp_ok;

    always #(CLK_PERIOD/2) clk = ~clk;

    amo_engine #(.DW(DW), .DEPTH(DEPTH), .TW(TW)) uut (.*);

    typedef struct {
        logic [DW-1:0] data;
        logic [TW-1:0] tag;
        logic          ok;
        string         req;
    } exp_t;

    exp_t          exp_q[$];
    logic [DW-1:0] ref_mem [DEPTH];
    int            n_cmp = 0;
    int            n_bad = 0;
    bit            bp_on = 0;
    bit            done  = 0;
    logic [TW-1:0] next_tag = '0;

    task automatic check(input bit good, input string req, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] expv);
        n_cmp++;
        if (!good) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic ref_clear();
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
        exp_q.delete();
    endtask

    // Caller is at a negedge; returns at a negedge with cmd_valid low.
    task automatic send(input logic [2:0] op, input logic [AW-1:0] a,
                        input logic [DW-1:0] opnd, input logic [DW-1:0] cmpv,
                        input bit f, input string req);
        logic [DW-1:0] old, nv;
        bit ok;
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_operand = opnd;
        cmd_compare = cmpv; cmd_fetch = f; cmd_tag = next_tag;
        while (!cmd_ready) @(negedge clk);
        old = ref_mem[a];
        nv  = old;
        ok  = 1'b1;
        case (op)
            3'd0: nv = old + opnd;
            3'd1: nv = old & opnd;
            3'd2: nv = old | opnd;
            3'd3: nv = old ^ opnd;
            3'd4: if (old == cmpv) nv = opnd; else ok = 1'b0;
            default: ok = 1'b0;
        endcase
        ref_mem[a] = nv;
        if (f) exp_q.push_back('{old, next_tag, ok, req});
        next_tag = next_tag + 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic drain();
        bp_on = 0;
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic reset_and_count();
        int n;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        ref_clear();
        rst_n = 1'b1;
        n = 0;
        while (!cmd_ready && n < 4 * DEPTH) begin
            n++;
            @(negedge clk);
        end
        check(n == DEPTH, "R1", "clear cycles", DW'(n), DW'(DEPTH));
    endtask

    // Per-clock monitor: response ordering, contents and hold behaviour
    logic          p_valid = 0, p_ready = 0, p_ok = 0;
    logic [DW-1:0] p_data = '0;
    logic [TW-1:0] p_tag = '0;
    always @(negedge clk) begin
        if (!rst_n) begin
            p_valid = 0;
        end else begin
            if (p_valid && !p_ready) begin
                check(rsp_valid == 1'b1, "R7", "held valid", DW'(rsp_valid), 1);
                check(rsp_data == p_data && rsp_tag == p_tag && rsp_ok == p_ok,
                      "R7", "held data", rsp_data, p_data);
            end
            if (rsp_valid)
                check(!cmd_ready, "R7", "ready while rsp", DW'(cmd_ready), 0);
            rsp_ready = bp_on ? ($urandom_range(2) == 0) : 1'b1;
            if (rsp_valid && rsp_ready) begin
                if (exp_q.size() == 0) begin
                    check(0, "R5", "unexpected response", DW'(rsp_tag), 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(rsp_data == e.data, e.req, "data", rsp_data, e.data);
                    check(rsp_tag == e.tag, "R5", "tag", DW'(rsp_tag), DW'(e.tag));
                    check(rsp_ok == e.ok, e.req, "ok", DW'(rsp_ok), DW'(e.ok));
                end
            end
            p_valid = rsp_valid; p_ready = rsp_ready;
            p_data = rsp_data; p_tag = rsp_tag; p_ok = rsp_ok;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: run did not finish");
        finish_run();
    end

    localparam logic [DW-1:0] ALL1 = '1;

    initial begin
        @(negedge clk);
        reset_and_count();

        // R1: words read as zero after clear
        send(3'd0, 6'd5, 64'd0, '0, 1, "R1");
        send(3'd0, 6'd63, 64'd0, '0, 1, "R1");

        // R2: add wraps
        send(3'd0, 6'd1, ALL1, '0, 0, "R2");
        send(3'd0, 6'd1, 64'd2, '0, 1, "R2");
        send(3'd0, 6'd1, 64'd0, '0, 1, "R2");

        // R3: logic ops
        send(3'd2, 6'd2, 64'hF0F0_0000_FFFF_1234, '0, 1, "R3");
        send(3'd1, 6'd2, 64'hFF00_FF00_00FF_FF00, '0, 1, "R3");
        send(3'd3, 6'd2, 64'h0123_4567_89AB_CDEF, '0, 1, "R3");
        send(3'd0, 6'd2, 64'd0, '0, 1, "R3");

        // R4: compare-and-swap hit and miss
        send(3'd4, 6'd3, 64'hAAAA, 64'd0, 1, "R4");
        send(3'd4, 6'd3, 64'hBBBB, 64'd1, 1, "R4");
        send(3'd4, 6'd3, 64'hCCCC, 64'hAAAA, 0, "R4");
        send(3'd0, 6'd3, 64'd0, '0, 1, "R4");

        // R8: undefined opcodes leave memory alone
        send(3'd5, 6'd3, 64'h1, 64'h0, 1, "R8");
        send(3'd7, 6'd3, 64'h1, 64'h0, 0, "R8");
        send(3'd6, 6'd3, 64'h1, 64'hCCCC, 1, "R8");
        send(3'd0, 6'd3, 64'd0, '0, 1, "R8");

        // R6: back-to-back same-address packet without fetch, then read
        for (int i = 0; i < 8; i++) send(3'd0, 6'd9, 64'(i + 1), '0, 0, "R6");
        send(3'd3, 6'd9, 64'hFF, '0, 0, "R6");
        send(3'd0, 6'd9, 64'd0, '0, 1, "R6");

        // R7: backpressure on mixed traffic over a small address pool
        bp_on = 1;
        for (int i = 0; i < 400; i++) begin
            logic [2:0] op;
            logic [AW-1:0] a;
            logic [DW-1:0] v;
            op = 3'($urandom_range(7));
            a  = AW'($urandom_range(3) + 16);
            v  = {$urandom(), $urandom()};
            if (op == 3'd4 && ($urandom_range(1) == 0)) v = ref_mem[a] + 1;
            send(op, a, v, ref_mem[a], bit'($urandom_range(1)), "R7");
        end
        drain();
        for (int a = 16; a < 20; a++) send(3'd0, AW'(a), 64'd0, '0, 1, "R6");
        drain();
        check(exp_q.size() == 0, "R5", "pending responses", DW'(exp_q.size()), 0);

        // R1: reset after dirtying memory clears it again
        reset_and_count();
        send(3'd0, 6'd9, 64'd0, '0, 1, "R1");
        send(3'd0, 6'd2, 64'd0, '0, 1, "R1");
        drain();
        finish_run();
    end

endmodule